// File: doc/BRIEF.md
# Drawing Command Packet Framer

This block sits at the front of a drawing engine and turns a flat stream of 32-bit command words into framed packets. The top byte of the first word of each packet is an opcode. A fixed table maps the opcode to the number of parameter words that follow. Each packet goes out with a start marker on its first word and an end marker on its last word. Line-strip opcodes have no fixed length. Their packet ends on a terminator word, which is recognised by a masked bit pattern, but only at word positions where a vertex could stand.

Three groups of opcodes are consumed and never emitted:
- Rectangle-transfer opcodes. Their position and size words go to a transfer unit as a one-cycle start pulse. For a write transfer, the data words that follow also go to the transfer unit and are not decoded as commands.
- Settings opcodes. They load one of eight settings registers. Two of those registers form the low bits of a status word.
- Opcodes with no parameter words. They are dropped as no-ops.

The input is a valid/ready stream. The output path is combinational from the input, so the input stalls only when the output has a word to give and the output is not ready.

Top module: `gpf_pkt_framer`

## Requirements
- R1: After reset, settings register i holds (0xE0 + i) << 24, status_low is 0, out_valid is low, and in_ready is high while no word is offered.
- R2: For a fixed-length drawing opcode, the packet is 1 + N words, where N depends on the opcode. For 0x20–0x3F, N by group of four in ascending order is 3, 6, 4, 8, 5, 8, 7, 11. For 0x40–0x47 N is 2, and for 0x50–0x57 N is 3. out_sop is 1 only on the first word and out_eop is 1 only on the last word. Words are emitted unchanged and in order.
- R3: For 0x60–0x7F, N by group of four is 2, 3, 1, 0, 1, 2, 1, 2. Opcode 0x02 has N = 2 and opcode 0x80 has N = 3.
- R4: A header whose opcode has N = 0 and no special role is consumed and produces no output. This covers 0x00, 0x6C–0x6F and 0xE8–0xEF.
- R5: Opcodes 0x48–0x4F are flat line strips. Index the packet's words from 0 (the header). The packet ends at the first word with index 3 or more for which (word & 0xF000F000) == 0x50005000. A matching word at index 1 or 2 is ordinary data.
- R6: Opcodes 0x58–0x5F are shaded line strips. The packet ends at the first matching word with an even index of 4 or more. A matching word at an odd index is ordinary data.
- R7: A header with opcode 0xE0–0xE7 stores the whole word into settings register (opcode & 7) and is not emitted. Register i appears on cfg_flat[32*i+31 : 32*i].
- R8: status_low[10:0] equals settings register 1 bits 10:0, and status_low[12:11] equals settings register 6 bits 1:0.
- R9: Opcodes 0xA0–0xDF consume three words and emit none. When the third word is accepted, xfer_start pulses for one cycle with xfer_pos set to the second word, xfer_size set to the third word, and xfer_read = 1 exactly when (opcode & 0xE0) == 0xC0.
- R10: After a write setup, the next ceil(W*H/2) accepted words appear on xfer_wvalid/xfer_wdata. These words are not decoded as commands and not emitted. W = ((size − 1) & 0x3FF) + 1 and H = (((size >> 16) − 1) & 0x1FF) + 1. After a read setup, the next word is decoded as a header.
- R11: in_ready is low only while out_valid is high and out_ready is low. No word is lost or duplicated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle when high with in_valid |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Packet word offered |
| out_ready | input | 1 | Downstream accepts packet word |
| out_word | output | 32 | Packet word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| xfer_start | output | 1 | One-cycle pulse: transfer setup complete |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wvalid | output | 1 | Write transfer data word valid |
| xfer_wdata | output | 32 | Write transfer data word |
| cfg_flat | output | 256 | Eight settings registers, register i in bits 32*i+31:32*i |
| status_low | output | 13 | Low status bits built from settings registers 1 and 6 |

## Verification
The assertions check three properties on every cycle:
- Packet framing stays consistent: a start marker appears only between packets, and a continuation word only inside one.
- Back-pressure is the only reason for a stall.
- Transfer data never coincides with packet output, and the settings registers change only after a settings-shaped word is accepted.

Only the bench scenarios can show the following:
- That each opcode group yields the right packet length.
- That terminator-looking words at forbidden line-strip positions pass as data.
- That header-looking words inside a write transfer are kept from the decoder.
- That the transfer word count follows the size formula, including an odd pixel count.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
  localparam int WORD_W = 32;
  localparam int CFG_N  = 8;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_BODY,
    ST_POLY,
    ST_XPAR,
    ST_XDAT
  } fr_state_e;

  // Parameter words following the header of a fixed-length opcode.
  function automatic logic [3:0] extra_words(input logic [7:0] op);
    logic [3:0] r;
    r = 4'd0;
    if (op == 8'h02) r = 4'd2;
    else if (op == 8'h80) r = 4'd3;
    else if (op[7:5] == 3'b001) begin
      case (op[4:2])
        3'd0: r = 4'd3;
        3'd1: r = 4'd6;
        3'd2: r = 4'd4;
        3'd3: r = 4'd8;
        3'd4: r = 4'd5;
        3'd5: r = 4'd8;
        3'd6: r = 4'd7;
        default: r = 4'd11;
      endcase
    end
    else if (op[7:4] == 4'h4) r = op[3] ? 4'd3 : 4'd2;
    else if (op[7:4] == 4'h5) r = op[3] ? 4'd4 : 4'd3;
    else if (op[7:5] == 3'b011) begin
      case (op[4:2])
        3'd0: r = 4'd2;
        3'd1: r = 4'd3;
        3'd2: r = 4'd1;
        3'd3: r = 4'd0;
        3'd4: r = 4'd1;
        3'd5: r = 4'd2;
        3'd6: r = 4'd1;
        default: r = 4'd2;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/gpf_op_decode.sv
module gpf_op_decode
  import gpf_pkg::*;
(
  input  logic [7:0] op,
  output logic [3:0] extra,
  output logic       is_poly,
  output logic       poly_shaded,
  output logic       is_xfer,
  output logic       xfer_rd,
  output logic       is_cfg
);
  always_comb begin
    extra       = extra_words(op);
    is_poly     = (op[7:5] == 3'b010) && op[3];
    poly_shaded = op[4];
    is_xfer     = (op >= 8'hA0) && (op <= 8'hDF);
    xfer_rd     = (op[7:5] == 3'b110);
    is_cfg      = (op[7:3] == 5'b11100);
  end
endmodule

// File: rtl/gpf_cfg_bank.sv
module gpf_cfg_bank
  import gpf_pkg::*;
#(
  parameter int N = CFG_N,
  parameter int W = WORD_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] cfg_flat,
  output logic [12:0]    status_low
);
  logic [W-1:0] reg_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[i] <= W'((32'hE0 + i) << 24);
      else if (sel) reg_q[i] <= wr_data;
    end
    assign cfg_flat[i*W +: W] = reg_q[i];
  end

  assign status_low = {reg_q[6][1:0], reg_q[1][10:0]};
endmodule

// File: rtl/gpf_xfer_len.sv
module gpf_xfer_len #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int Y_POS  = 16,
  localparam int CNT_W = X_BITS + Y_BITS
) (
  input  logic [31:0]      size_word,
  output logic [CNT_W-1:0] n_words
);
  logic [X_BITS-1:0]       w_m1;
  logic [Y_BITS-1:0]       h_m1;
  logic [X_BITS:0]         w_px;
  logic [Y_BITS:0]         h_px;
  logic [X_BITS+Y_BITS+1:0] pix;
  logic [X_BITS+Y_BITS+1:0] pix_r;

  always_comb begin
    w_m1  = size_word[X_BITS-1:0] - X_BITS'(1);
    h_m1  = size_word[Y_POS +: Y_BITS] - Y_BITS'(1);
    w_px  = {1'b0, w_m1} + (X_BITS+1)'(1);
    h_px  = {1'b0, h_m1} + (Y_BITS+1)'(1);
    pix   = (X_BITS+Y_BITS+2)'(w_px) * (X_BITS+Y_BITS+2)'(h_px);
    pix_r = (pix + (X_BITS+Y_BITS+2)'(1)) >> 1;
    n_words = pix_r[CNT_W-1:0];
  end
endmodule

// File: rtl/gpf_pkt_framer.sv
module gpf_pkt_framer
  import gpf_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  localparam int CNT_W = X_BITS + Y_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_word,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_word,
  output logic                    out_sop,
  output logic                    out_eop,
  output logic                    xfer_start,
  output logic                    xfer_read,
  output logic [WORD_W-1:0]       xfer_pos,
  output logic [WORD_W-1:0]       xfer_size,
  output logic                    xfer_wvalid,
  output logic [WORD_W-1:0]       xfer_wdata,
  output logic [CFG_N*WORD_W-1:0] cfg_flat,
  output logic [12:0]             status_low
);
  fr_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] pos_q, pos_d;
  logic              rd_q, rd_d;
  logic              shd_q, shd_d;
  logic [2:0]        kc_q, kc_d;
  logic              par_q, par_d;

  logic [3:0]        extra;
  logic              is_poly, poly_shaded, is_xfer, xfer_rd, is_cfg;
  logic              emit_hdr, acc, term_ok, cfg_we;
  logic [CNT_W-1:0]  xwords;

  gpf_op_decode u_dec (
    .op          (in_word[31:24]),
    .extra       (extra),
    .is_poly     (is_poly),
    .poly_shaded (poly_shaded),
    .is_xfer     (is_xfer),
    .xfer_rd     (xfer_rd),
    .is_cfg      (is_cfg)
  );

  gpf_xfer_len #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_len (
    .size_word (in_word),
    .n_words   (xwords)
  );

  assign emit_hdr = !is_xfer && (is_poly || (extra != 4'd0));
  assign term_ok  = ((in_word & 32'hF000_F000) == 32'h5000_5000) &&
                    (shd_q ? ((kc_q == 3'd4) && !par_q) : (kc_q >= 3'd3));

  // Handshake and output steering
  always_comb begin
    out_word    = in_word;
    xfer_wdata  = in_word;
    xfer_pos    = pos_q;
    xfer_size   = in_word;
    xfer_read   = rd_q;
    out_valid   = 1'b0;
    out_sop     = 1'b0;
    out_eop     = 1'b0;
    in_ready    = 1'b1;
    xfer_start  = 1'b0;
    xfer_wvalid = 1'b0;
    case (state_q)
      ST_HDR: begin
        out_valid = in_valid && emit_hdr;
        out_sop   = 1'b1;
        in_ready  = emit_hdr ? out_ready : 1'b1;
      end
      ST_BODY: begin
        out_valid = in_valid;
        out_eop   = (cnt_q == CNT_W'(1));
        in_ready  = out_ready;
      end
      ST_POLY: begin
        out_valid = in_valid;
        out_eop   = term_ok;
        in_ready  = out_ready;
      end
      ST_XPAR: xfer_start  = in_valid && (cnt_q == CNT_W'(1));
      ST_XDAT: xfer_wvalid = in_valid;
      default: ;
    endcase
  end

  assign acc    = in_valid && in_ready;
  assign cfg_we = acc && (state_q == ST_HDR) && is_cfg;

  // Next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pos_d   = pos_q;
    rd_d    = rd_q;
    shd_d   = shd_q;
    kc_d    = kc_q;
    par_d   = par_q;
    case (state_q)
      ST_HDR: begin
        if (is_xfer) begin
          state_d = ST_XPAR;
          cnt_d   = '0;
          rd_d    = xfer_rd;
        end else if (is_poly) begin
          state_d = ST_POLY;
          shd_d   = poly_shaded;
          kc_d    = 3'd1;
          par_d   = 1'b1;
        end else if (extra != 4'd0) begin
          state_d = ST_BODY;
          cnt_d   = CNT_W'(extra);
        end
      end
      ST_BODY: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_d = ST_HDR;
      end
      ST_POLY: begin
        if (term_ok) state_d = ST_HDR;
        kc_d  = (kc_q == 3'd4) ? 3'd4 : kc_q + 3'd1;
        par_d = !par_q;
      end
      ST_XPAR: begin
        if (cnt_q == '0) begin
          pos_d = in_word;
          cnt_d = CNT_W'(1);
        end else if (rd_q) begin
          state_d = ST_HDR;
        end else begin
          state_d = ST_XDAT;
          cnt_d   = xwords;
        end
      end
      ST_XDAT: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_d = ST_HDR;
      end
      default: state_d = ST_HDR;
    endcase
  end

  // Registers, enabled by an accepted word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      pos_q   <= '0;
      rd_q    <= 1'b0;
      shd_q   <= 1'b0;
      kc_q    <= 3'd0;
      par_q   <= 1'b0;
    end else if (acc) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pos_q   <= pos_d;
      rd_q    <= rd_d;
      shd_q   <= shd_d;
      kc_q    <= kc_d;
      par_q   <= par_d;
    end
  end

  gpf_cfg_bank u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_idx     (in_word[26:24]),
    .wr_data    (in_word),
    .cfg_flat   (cfg_flat),
    .status_low (status_low)
  );
endmodule

// File: rtl/gpf_pkt_framer_chk.sv
module gpf_pkt_framer_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [31:0]  in_word,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_sop,
  input logic         out_eop,
  input logic         xfer_wvalid,
  input logic [255:0] cfg_flat
);
  logic in_pkt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (out_valid && out_ready) begin
      if (out_eop) in_pkt <= 1'b0;
      else if (out_sop) in_pkt <= 1'b1;
    end
  end

  // R2
  sop_between_pkts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !in_pkt);

  // R2
  body_inside_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> in_pkt);

  // R11
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (out_valid && !out_ready));

  // R10
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_wvalid |-> !out_valid);

  // R7
  cfg_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flat != $past(cfg_flat)) |->
      $past(in_valid && in_ready && (in_word[31:27] == 5'b11100)));
endmodule

bind gpf_pkt_framer gpf_pkt_framer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_word     (in_word),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .xfer_wvalid (xfer_wvalid),
  .cfg_flat    (cfg_flat)
);

// File: tb/test_gpf_pkt_framer.sv
module test_gpf_pkt_framer;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n;
  logic         in_valid, in_ready;
  logic [31:0]  in_word;
  logic         out_valid, out_ready, out_sop, out_eop;
  logic [31:0]  out_word;
  logic         xfer_start, xfer_read, xfer_wvalid;
  logic [31:0]  xfer_pos, xfer_size, xfer_wdata;
  logic [255:0] cfg_flat;
  logic [12:0]  status_low;

  gpf_pkt_framer i_gpf_pkt_framer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_sop(out_sop), .out_eop(out_eop),
    .xfer_start(xfer_start), .xfer_read(xfer_read),
    .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .xfer_wvalid(xfer_wvalid), .xfer_wdata(xfer_wdata),
    .cfg_flat(cfg_flat), .status_low(status_low)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic stall_on = 1'b0;

  logic [33:0] pkt_q [$];
  logic [64:0] xs_q  [$];
  logic [31:0] xd_q  [$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready <= stall_on ? (cyc % 3 != 1) : 1'b1;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  // Monitor: packet, transfer start and transfer data scoreboards
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (pkt_q.size() == 0) check(0, "R4 unexpected packet word", {30'd0, out_sop, out_eop, out_word}, 0);
        else begin
          logic [33:0] e;
          e = pkt_q.pop_front();
          check({out_sop, out_eop, out_word} == e, "R2 packet word", {30'd0, out_sop, out_eop, out_word}, {30'd0, e});
        end
      end
      if (rst_n && xfer_start) begin
        if (xs_q.size() == 0) check(0, "R9 unexpected xfer_start", 0, 1);
        else begin
          logic [64:0] e;
          e = xs_q.pop_front();
          check({xfer_read, xfer_pos, xfer_size} == e, "R9 transfer setup", {xfer_pos, xfer_size}, e[63:0]);
        end
      end
      if (rst_n && xfer_wvalid) begin
        if (xd_q.size() == 0) check(0, "R10 unexpected xfer data", xfer_wdata, 0);
        else begin
          logic [31:0] e;
          e = xd_q.pop_front();
          check(xfer_wdata == e, "R10 transfer data", xfer_wdata, e);
        end
      end
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'h0;
  endtask

  task automatic exp_word(input logic [31:0] w, input bit sop, input bit eop);
    pkt_q.push_back({sop, eop, w});
  endtask

  // Sends a fixed-length packet of n words starting with header h
  task automatic fixed_pkt(input logic [31:0] h, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = (i == 0) ? h : (32'h0100_0000 * i + h[23:0] + i);
      exp_word(w, i == 0, i == n - 1);
    end
    for (int i = 0; i < n; i++) begin
      send((i == 0) ? h : (32'h0100_0000 * i + h[23:0] + i));
    end
  endtask

  task automatic drain();
    repeat (4) idle();
    check(pkt_q.size() == 0, "R11 packet queue drained", pkt_q.size(), 0);
  endtask

  initial begin
    in_valid = 1'b0;
    in_word  = 32'h0;
    out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    for (int i = 0; i < 8; i++)
      check(cfg_flat[32*i +: 32] == ((32'hE0 + i) << 24), "R1 settings reset", cfg_flat[32*i +: 32], (32'hE0 + i) << 24);
    check(status_low == 13'h0, "R1 status reset", status_low, 0);
    check(!out_valid && in_ready, "R1 idle handshake", {out_valid, in_ready}, 2'b01);

    // R2 fixed lengths
    fixed_pkt(32'h2011_2233, 4);
    fixed_pkt(32'h2400_0001, 7);
    fixed_pkt(32'h4400_0002, 3);
    fixed_pkt(32'h5400_0003, 4);
    stall_on = 1'b1;
    fixed_pkt(32'h3C00_0004, 12);   // R11 under back-pressure
    fixed_pkt(32'h3400_0005, 9);
    stall_on = 1'b0;
    drain();

    // R3 rectangle groups, fill and copy
    fixed_pkt(32'h6800_0006, 2);
    fixed_pkt(32'h7C00_0007, 3);
    fixed_pkt(32'h6400_0008, 4);
    fixed_pkt(32'h0200_0009, 3);
    fixed_pkt(32'h8000_000A, 4);

    // R4 no-ops dropped, next packet intact
    send(32'h0000_0000);
    send(32'h6C12_3456);
    send(32'hEA00_0000);
    fixed_pkt(32'h6000_000B, 3);
    drain();

    // R5 flat strip: matching words at index 1,2 are data; ends at index 4
    exp_word(32'h4800_00FF, 1, 0);
    exp_word(32'h5000_5000, 0, 0);
    exp_word(32'h5111_5222, 0, 0);
    exp_word(32'h0010_0010, 0, 0);
    exp_word(32'h5ABC_5DEF, 0, 1);
    send(32'h4800_00FF); send(32'h5000_5000); send(32'h5111_5222);
    send(32'h0010_0010); send(32'h5ABC_5DEF);
    fixed_pkt(32'h2000_000C, 4);
    drain();

    // R6 shaded strip: match at index 3 and 5 is data; ends at index 6
    stall_on = 1'b1;
    exp_word(32'h5800_0001, 1, 0);
    exp_word(32'h0001_0001, 0, 0);
    exp_word(32'h0000_00AA, 0, 0);
    exp_word(32'h5000_5000, 0, 0);
    exp_word(32'h0000_00BB, 0, 0);
    exp_word(32'h5000_5001, 0, 0);
    exp_word(32'h5555_5555, 0, 1);
    send(32'h5800_0001); send(32'h0001_0001); send(32'h0000_00AA);
    send(32'h5000_5000); send(32'h0000_00BB); send(32'h5000_5001);
    send(32'h5555_5555);
    stall_on = 1'b0;
    drain();

    // R7 / R8 settings
    send(32'hE100_0ABC);
    @(negedge clk); #2;
    check(cfg_flat[63:32] == 32'hE100_0ABC, "R7 settings reg1", cfg_flat[63:32], 32'hE100_0ABC);
    check(status_low == 13'h02BC, "R8 status from reg1", status_low, 13'h02BC);
    send(32'hE600_0003);
    @(negedge clk); #2;
    check(cfg_flat[223:192] == 32'hE600_0003, "R7 settings reg6", cfg_flat[223:192], 32'hE600_0003);
    check(status_low == 13'h1ABC, "R8 status from reg1 and reg6", status_low, 13'h1ABC);

    // R9 / R10 write transfer 3x2 -> 3 words, header-like data not decoded
    xs_q.push_back({1'b0, 32'h0010_0020, 32'h0002_0003});
    xd_q.push_back(32'h20AA_AAAA);
    xd_q.push_back(32'hE1FF_FFFF);
    xd_q.push_back(32'h1234_5678);
    send(32'hA000_0000); send(32'h0010_0020); send(32'h0002_0003);
    send(32'h20AA_AAAA); send(32'hE1FF_FFFF); send(32'h1234_5678);
    fixed_pkt(32'h6800_000D, 2);
    drain();
    check(cfg_flat[63:32] == 32'hE100_0ABC, "R10 data word did not write settings", cfg_flat[63:32], 32'hE100_0ABC);

    // R10 odd pixel count 3x1 -> 2 words
    xs_q.push_back({1'b0, 32'h0000_0000, 32'h0001_0003});
    xd_q.push_back(32'hDEAD_0001);
    xd_q.push_back(32'hDEAD_0002);
    send(32'hA500_0000); send(32'h0000_0000); send(32'h0001_0003);
    send(32'hDEAD_0001); send(32'hDEAD_0002);
    fixed_pkt(32'h2000_000E, 4);
    drain();

    // R9 read transfer: next word is a header
    xs_q.push_back({1'b1, 32'h0004_0008, 32'h0010_0010});
    send(32'hC000_0000); send(32'h0004_0008); send(32'h0010_0010);
    fixed_pkt(32'h0200_000F, 3);
    drain();
    check(xs_q.size() == 0 && xd_q.size() == 0, "R9 transfer queues drained", xs_q.size() + xd_q.size(), 0);

    report();
  end
endmodule